// File: doc/BRIEF.md
# PIR Pulse Qualification and Mode Logic

This block sits behind an external window comparator that watches an amplified passive-infrared signal. The comparator gives two level inputs: one for a positive excursion and one for a negative excursion. The block turns them into a single-cycle detection trigger.

Each polarity has its own persistence filter. A filter emits one detection pulse once its input has stayed high for a programmed number of timing ticks. A mode code then decides how detections become a trigger:

- **Single-pulse:** either polarity alone fires.
- **Concurrent-pulse:** the trigger needs a positive and a negative one-shot to be active together. Each one-shot is retriggerable.
- **Dual-pulse:** any two detections inside a programmed window fire.

All durations are counted in ticks of a clock-enable input. These ticks replace the resistor-capacitor timing networks of an analogue design.

A filter-enable input holds both filters idle. This is typically used during power-up, while the analogue front end settles.

Top module: `pir_qualifier`

## Requirements
- R1: Each polarity input has its own filter. After `filt_len` (1 or more) consecutive ticks with the input high and `filt_en` high, the filter issues exactly one detection. A single-pulse trigger then appears one clock after the edge that counted the last tick. Holding the input high longer gives no further detection.
- R2: If a filter's input drops before the count completes, the count restarts from zero on the next assertion.
- R3: While `filt_en` is low, both filters stay cleared and issue no detection.
- R4: Filter counts, one-shot widths and window lengths advance only on clock edges where `tick` is high.
- R5: The mode code is 00 = single-pulse, 01 = concurrent-pulse, 10 = dual-pulse. Code 11 never asserts `trig`.
- R6: In single-pulse mode, a detection of either polarity asserts `trig` on the next clock.
- R7: A detection loads its polarity's one-shot with `shot_len`. The one-shot stays active for that many ticks, and a new detection reloads it.
- R8: In concurrent-pulse mode, `trig` pulses once on the clock after the positive and negative one-shots become active together. If the negative detection comes `d` cycles after the positive one, the trigger fires only when `d` < `shot_len`.
- R9: In dual-pulse mode, a first detection opens a window of `win_len` ticks. A second detection of either polarity fires the trigger if it arrives while the window is open. Two detections in the same cycle fire at once.
- R10: The dual-pulse window closes when it fires or when it expires. After that, a further detection opens a new window and does not fire. Leaving dual-pulse mode also closes the window.
- R11: `trig` is low out of reset and is a registered pulse. A qualifying event gives a one-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timing clock-enable |
| filt_en | input | 1 | Filter enable; low holds both filters idle |
| pos_in | input | 1 | Positive-excursion comparator level |
| neg_in | input | 1 | Negative-excursion comparator level |
| mode | input | 2 | Qualification mode code |
| filt_len | input | CNT_W | Persistence time in ticks |
| shot_len | input | CNT_W | One-shot width in ticks |
| win_len | input | CNT_W | Dual-pulse window in ticks |
| trig | output | 1 | Single-cycle detection trigger |

## Verification
Two functions can fall in the same cycle: the positive and negative filters can complete together. In dual-pulse mode, that simultaneous pair must count as two detections and fire at once. In concurrent-pulse mode, it must make both one-shots rise together.

The bench provokes this by sweeping the offset between the two polarity inputs from zero upward in both modes. Zero offset is the coincident case. For each offset, the bench computes the expected firing decision and firing cycle from `filt_len`, `shot_len` and `win_len`, and compares the observed `trig` cycle against it.

The offset equal to the window length is the other coincidence judged. There, the second detection lands in the last open cycle of the window and must still fire.

// File: rtl/pir_qualifier.sv
module pir_qualifier #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             filt_en,
  input  logic             pos_in,
  input  logic             neg_in,
  input  logic [1:0]       mode,
  input  logic [CNT_W-1:0] filt_len,
  input  logic [CNT_W-1:0] shot_len,
  input  logic [CNT_W-1:0] win_len,
  output logic             trig
);
  localparam logic [1:0] M_SP = 2'b00;
  localparam logic [1:0] M_CP = 2'b01;
  localparam logic [1:0] M_DP = 2'b10;

  logic [1:0]       raw;
  logic [1:0]       det;
  logic [1:0]       act;
  logic [CNT_W-1:0] win_cnt;
  logic             both, both_q, win_open, dp_fire, fire;

  assign raw = {neg_in, pos_in};

  for (genvar i = 0; i < 2; i++) begin : g_pol
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] shot;
    logic             done;
    logic             pulse;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt   <= '0;
        done  <= 1'b0;
        pulse <= 1'b0;
      end else begin
        pulse <= 1'b0;
        if (!filt_en || !raw[i]) begin
          cnt  <= '0;
          done <= 1'b0;
        end else if (tick && !done) begin
          if (cnt >= filt_len - 1'b1) begin
            cnt   <= '0;
            done  <= 1'b1;
            pulse <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 shot <= '0;
      else if (pulse)             shot <= shot_len;
      else if (tick && shot != 0) shot <= shot - 1'b1;
    end

    assign det[i] = pulse;
    assign act[i] = (shot != '0);
  end

  assign both     = &act;
  assign win_open = (win_cnt != '0);
  assign dp_fire  = (win_open && |det) || &det;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    win_cnt <= '0;
    else if (mode != M_DP)         win_cnt <= '0;
    else if (dp_fire)              win_cnt <= '0;
    else if (|det)                 win_cnt <= win_len;
    else if (tick && win_open)     win_cnt <= win_cnt - 1'b1;
  end

  always_comb begin
    case (mode)
      M_SP:    fire = |det;
      M_CP:    fire = both && !both_q;
      M_DP:    fire = dp_fire;
      default: fire = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      both_q <= 1'b0;
      trig   <= 1'b0;
    end else begin
      both_q <= both;
      trig   <= fire;
    end
  end
endmodule

module pir_qualifier_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             filt_en,
  input logic [1:0]       mode,
  input logic [CNT_W-1:0] shot_len,
  input logic [1:0]       det,
  input logic [1:0]       act,
  input logic [CNT_W-1:0] win_cnt,
  input logic             trig
);
  assert_filter_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !filt_en |=> det == 2'b00);
  assert_pos_once_R1: assert property (@(posedge clk) disable iff (!rst_n)
    det[0] |=> !det[0]);
  assert_neg_once_R1: assert property (@(posedge clk) disable iff (!rst_n)
    det[1] |=> !det[1]);
  assert_shot_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (det[0] && shot_len != 0) |=> act[0]);
  assert_sp_fire_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00 && det != 2'b00) |=> trig);
  assert_cp_needs_both_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01 && act != 2'b11) |=> !trig);
  assert_dp_second_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10 && win_cnt != 0 && det != 2'b00) |=> (trig && win_cnt == 0));
  assert_mode_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'b11 |=> !trig);
endmodule

bind pir_qualifier pir_qualifier_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .filt_en(filt_en), .mode(mode),
  .shot_len(shot_len), .det(det), .act(act), .win_cnt(win_cnt), .trig(trig)
);

// File: tb/tb_pir_qualifier.sv
module tb_pir_qualifier;
  localparam int CNT_W = 8;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b1, filt_en = 1'b1;
  logic pos_in = 1'b0, neg_in = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [CNT_W-1:0] filt_len = 8'd2, shot_len = 8'd3, win_len = 8'd3;
  logic trig;

  int tests = 0, fails = 0;
  int first_hit, hits;

  always #5 clk = ~clk;

  pir_qualifier #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .filt_en(filt_en),
    .pos_in(pos_in), .neg_in(neg_in), .mode(mode), .filt_len(filt_len),
    .shot_len(shot_len), .win_len(win_len), .trig(trig)
  );

  task automatic chk(input bit ok, input string tag, input int act_v, input int exp_v);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act_v, exp_v);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    pos_in = 1'b0; neg_in = 1'b0; rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // pos high from index dp (except index gap), neg high from index dn
  task automatic run(input int dp, input int dn, input int gap, input int n);
    first_hit = 0; hits = 0;
    for (int k = 0; k < n; k++) begin
      pos_in = (k >= dp) && (k != gap);
      neg_in = (k >= dn);
      @(posedge clk);
      @(negedge clk);
      if (trig) begin
        hits++;
        if (first_hit == 0) first_hit = k + 1;
      end
    end
    pos_in = 1'b0; neg_in = 1'b0;
  endtask

  initial begin
    #2000000;
    fails++; tests++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int L, exp_hits, exp_idx;
    do_reset();
    chk(trig == 1'b0, "R11 reset", int'(trig), 0);

    // R1/R6 single-pulse sweep over filter length and polarity
    mode = 2'b00;
    for (int l = 1; l <= 6; l++) begin
      for (int pol = 0; pol < 2; pol++) begin
        filt_len = l[CNT_W-1:0];
        do_reset();
        if (pol == 0) run(0, 1000, -1, 30);
        else          run(1000, 0, -1, 30);
        chk(hits == 1, "R1 one detection per hold", hits, 1);
        chk(first_hit == l + 1, "R6 single-pulse timing", first_hit, l + 1);
      end
    end

    // R2 restart after drop
    L = 4; filt_len = 8'd4;
    do_reset();
    run(0, 1000, L - 1, 30);
    chk(first_hit == 2 * L + 1, "R2 restart", first_hit, 2 * L + 1);

    // R3 filter enable
    do_reset();
    filt_en = 1'b0;
    run(0, 0, -1, 30);
    chk(hits == 0, "R3 filters idle", hits, 0);
    filt_en = 1'b1;

    // R4 tick gating
    L = 2; filt_len = 8'd2;
    do_reset();
    tick = 1'b0;
    run(0, 1000, -1, 20);
    chk(hits == 0, "R4 no tick no count", hits, 0);
    tick = 1'b1;
    run(0, 1000, -1, 20);
    chk(first_hit == L + 1, "R4 counts on tick", first_hit, L + 1);

    // R5 unused mode code
    mode = 2'b11;
    do_reset();
    run(0, 0, -1, 30);
    chk(hits == 0, "R5 code 11 silent", hits, 0);

    // R7/R8 concurrent-pulse offset sweep
    mode = 2'b01; shot_len = 8'd3;
    for (int d = 0; d <= 5; d++) begin
      do_reset();
      run(0, d, -1, L + d + 12);
      exp_hits = (d < 3) ? 1 : 0;
      exp_idx  = (d < 3) ? d + L + 2 : 0;
      chk(hits == exp_hits, "R8 overlap decision", hits, exp_hits);
      chk(first_hit == exp_idx, "R7 one-shot window timing", first_hit, exp_idx);
      run(1000, 1000, -1, 10);
    end

    // R9 dual-pulse offset sweep
    mode = 2'b10; win_len = 8'd3;
    for (int d = 0; d <= 5; d++) begin
      do_reset();
      run(0, d, -1, L + d + 12);
      exp_hits = (d <= 3) ? 1 : 0;
      exp_idx  = (d <= 3) ? d + L + 1 : 0;
      chk(hits == exp_hits, "R9 window decision", hits, exp_hits);
      chk(first_hit == exp_idx, "R9 window timing", first_hit, exp_idx);
    end

    // R9 same polarity twice, inside and outside window
    do_reset();
    win_len = 8'd3;
    run(0, 1000, L, 20);
    chk(first_hit == 2 * L + 2, "R9 same polarity fires", first_hit, 2 * L + 2);
    do_reset();
    win_len = 8'd2;
    run(0, 1000, L, 20);
    chk(hits == 0, "R10 window expired", hits, 0);

    // R10 window cleared after firing
    do_reset();
    win_len = 8'd10;
    run(0, 0, L, 20);
    chk(hits == 1, "R10 cleared after fire", hits, 1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule